// File: doc/BRIEF.md
# CAN Transceiver Mode and Wake-Up Controller

This block is the digital control core of a CAN physical-layer interface. It chooses between normal operation and a low-power standby from a host standby request and two supply-undervoltage flags, one for the main supply and one for the I/O supply. It enables the transmit driver only in normal operation, and it produces the receive output together with that output's enable. The host request and the undervoltage flags each pass through a two-flop synchronizer before the block uses them. The bus-dominant input arrives already sampled in the clock domain and is used directly.

In normal operation the receive output is the inverse of the bus-dominant input, with no register in the path. In standby a filter counts consecutive dominant samples. Once the count reaches `WAKE_CYC`, the receive output goes low to signal a wake-up. If the bus is dominant at the moment standby begins, wake-up reporting is locked out until the bus is seen recessive. While the I/O supply is undervoltage, the receive output is released (its enable is low) and the filter is held cleared. Setting `HAS_WAKE` to 0 builds the variant without a filter, which keeps the receive output high throughout standby. No pin carries a data stream, so every port is a plain level signal and none has a valid/ready handshake.

Top module: `can_mode_wake_ctrl`

## Requirements
- R1: `mode_o` uses the codes 2'b00 normal, 2'b01 host standby and 2'b10 undervoltage standby. With no undervoltage present, a synchronized standby request of 0 selects 2'b00 and a request of 1 selects 2'b01.
- R2: If either synchronized undervoltage flag is 1, `mode_o` becomes 2'b10 whatever the standby request is. Once both flags clear, the mode follows the standby request again.
- R3: In standby with the filter present, `rxd_o` goes low in the cycle after the `WAKE_CYC`-th consecutive dominant sample. It stays low while the bus stays dominant and returns high one cycle after the first recessive sample.
- R4: A dominant run shorter than `WAKE_CYC` samples reports no wake-up, and the next dominant run counts again from zero.
- R5: If the bus was dominant on the last clock edge of normal mode, no wake-up is reported in standby until a recessive sample has been seen. Dominant runs that start after that sample are filtered as usual.
- R6: While the synchronized I/O undervoltage flag is 1, `rxd_oe_o` is 0, `rxd_o` is 1 and the filter count is held at zero.
- R7: With `HAS_WAKE` = 0, `rxd_o` is 1 in every mode other than 2'b00.
- R8: `tx_en_o` is 1 only while `mode_o` is 2'b00.
- R9: In mode 2'b00 with `rxd_oe_o` high, `rxd_o` equals the inverse of `bus_dom_i` in the same cycle.
- R10: A change on `stby_req_i`, `vcc_uv_i` or `vio_uv_i` reaches `mode_o` after the third rising clock edge. A change on `vio_uv_i` reaches `rxd_oe_o` after the second edge.
- R11: A synchronous reset sets `mode_o` to 2'b01, `tx_en_o` to 0, `rxd_oe_o` to 1 and `rxd_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_req_i | input | 1 | Host standby request (1 = standby) |
| vcc_uv_i | input | 1 | Main supply undervoltage flag |
| vio_uv_i | input | 1 | I/O supply undervoltage flag |
| bus_dom_i | input | 1 | Sampled bus state (1 = dominant) |
| mode_o | output | 2 | Operating mode code |
| tx_en_o | output | 1 | Transmit driver enable |
| rxd_o | output | 1 | Receive output (0 = dominant / wake-up) |
| rxd_oe_o | output | 1 | Receive output enable (0 = released) |

## Verification
The bench aims at the filter's exact threshold. It drives a dominant run one sample short of `WAKE_CYC` and then one run that reaches it. A filter that fires early or late, or whose count survives a recessive sample, shows up as an early or missing low on `rxd_o`. The bench enters standby while the bus is already dominant and holds it dominant for several filter periods. A missing lockout shows up as a false wake-up, and a lockout that never releases as a missed wake-up afterwards. It also releases the I/O undervoltage while the bus is still dominant. A counter that was not held at zero would then report a wake-up too soon. The bench also checks that the mode changes after the third edge and the output enable after the second, so a synchronizer with the wrong depth is caught.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_STBY   = 2'b01,
    MD_UVSTBY = 2'b10
  } op_mode_e;

  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/cmw_sync.sv
module cmw_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  import can_mode_pkg::*;

  logic [WIDTH-1:0] stage_q [SYNC_DEPTH];

  generate
    for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stage_q[s] <= d_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[SYNC_DEPTH-1];

endmodule

// File: rtl/cmw_mode_fsm.sv
module cmw_mode_fsm
  import can_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     stby_s_i,
  input  logic     vcc_uv_s_i,
  input  logic     vio_uv_s_i,
  output op_mode_e mode_o
);

  op_mode_e mode_q, mode_d;

  always_comb begin
    if (vcc_uv_s_i || vio_uv_s_i) begin
      mode_d = MD_UVSTBY;
    end else if (stby_s_i) begin
      mode_d = MD_STBY;
    end else begin
      mode_d = MD_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MD_STBY;
    else     mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_UV_FORCES_STBY: assert property (@(posedge clk) disable iff (rst)
    (vcc_uv_s_i || vio_uv_s_i) |=> (mode_q == MD_UVSTBY)); // R2

  AST_REQ_SELECTS_STBY: assert property (@(posedge clk) disable iff (rst)
    (!vcc_uv_s_i && !vio_uv_s_i && stby_s_i) |=> (mode_q == MD_STBY)); // R1

  AST_REQ_SELECTS_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (!vcc_uv_s_i && !vio_uv_s_i && !stby_s_i) |=> (mode_q == MD_NORMAL)); // R1

endmodule

// File: rtl/cmw_wake_mon.sv
module cmw_wake_mon #(
  parameter int unsigned WAKE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_stby_i,
  input  logic bus_dom_i,
  input  logic vio_uv_s_i,
  output logic wake_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;
  logic          lock_q;
  logic          clr;

  assign clr = !in_stby_i || lock_q || !bus_dom_i || vio_uv_s_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (!in_stby_i) begin
      lock_q <= bus_dom_i;
    end else if (!bus_dom_i) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wake_o = in_stby_i && (cnt_q == CNT_TOP);

  AST_LOCK_BLOCKS_WAKE: assert property (@(posedge clk) disable iff (rst)
    (in_stby_i && lock_q) |-> !wake_o); // R5

  AST_WAKE_NEEDS_DOM: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> $past(bus_dom_i)); // R3

  AST_VIO_UV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    vio_uv_s_i |=> (cnt_q == '0)); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_TOP); // R4

endmodule

// File: rtl/can_mode_wake_ctrl.sv
module can_mode_wake_ctrl
  import can_mode_pkg::*;
#(
  parameter bit          HAS_WAKE = 1'b1,
  parameter int unsigned WAKE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stby_req_i,
  input  logic       vcc_uv_i,
  input  logic       vio_uv_i,
  input  logic       bus_dom_i,
  output logic [1:0] mode_o,
  output logic       tx_en_o,
  output logic       rxd_o,
  output logic       rxd_oe_o
);

  logic [2:0] raw_in, sync_out;
  logic       stby_s, vcc_uv_s, vio_uv_s;
  op_mode_e   mode;
  logic       in_stby;
  logic       wake;

  assign raw_in = {stby_req_i, vcc_uv_i, vio_uv_i};

  cmw_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_out)
  );

  assign {stby_s, vcc_uv_s, vio_uv_s} = sync_out;

  cmw_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stby_s_i   (stby_s),
    .vcc_uv_s_i (vcc_uv_s),
    .vio_uv_s_i (vio_uv_s),
    .mode_o     (mode)
  );

  assign in_stby = (mode != MD_NORMAL);

  generate
    if (HAS_WAKE) begin : g_wake
      cmw_wake_mon #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .in_stby_i  (in_stby),
        .bus_dom_i  (bus_dom_i),
        .vio_uv_s_i (vio_uv_s),
        .wake_o     (wake)
      );
    end else begin : g_nowake
      assign wake = 1'b0;
    end
  endgenerate

  always_comb begin
    if (vio_uv_s)     rxd_o = 1'b1;
    else if (!in_stby) rxd_o = !bus_dom_i;
    else              rxd_o = !wake;
  end

  assign rxd_oe_o = !vio_uv_s;
  assign tx_en_o  = !in_stby;
  assign mode_o   = mode;

  AST_RELEASED_RXD_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rxd_oe_o |-> rxd_o); // R6

  generate
    if (!HAS_WAKE) begin : g_chk_nowake
      AST_NOWAKE_RXD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'b00) |-> rxd_o); // R7
    end
  endgenerate

endmodule

// File: tb/test_can_mode_wake_ctrl.sv
module test_can_mode_wake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, stby, vcc_uv, vio_uv, bus;
  logic [1:0] mode_a, mode_b;
  logic tx_a, tx_b, rxd_a, rxd_b, oe_a, oe_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  int sq_stby [$];
  int sq_vcc  [$];
  int sq_vio  [$];
  int m_mode, m_lock, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_wake_ctrl #(.HAS_WAKE(1'b1), .WAKE_CYC(W)) i_can_mode_wake_ctrl (
    .clk(clk), .rst(rst), .stby_req_i(stby), .vcc_uv_i(vcc_uv), .vio_uv_i(vio_uv),
    .bus_dom_i(bus), .mode_o(mode_a), .tx_en_o(tx_a), .rxd_o(rxd_a), .rxd_oe_o(oe_a));

  can_mode_wake_ctrl #(.HAS_WAKE(1'b0), .WAKE_CYC(W)) i_can_mode_wake_ctrl_nowake (
    .clk(clk), .rst(rst), .stby_req_i(stby), .vcc_uv_i(vcc_uv), .vio_uv_i(vio_uv),
    .bus_dom_i(bus), .mode_o(mode_b), .tx_en_o(tx_b), .rxd_o(rxd_b), .rxd_oe_o(oe_b));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int vio_s();
    return sq_vio[0];
  endfunction

  function automatic int exp_rxd_wake();
    if (vio_s() != 0) return 1;
    if (m_mode == 0) return bus ? 0 : 1;
    return (m_cnt == W) ? 0 : 1;
  endfunction

  function automatic int exp_rxd_plain();
    if (vio_s() != 0) return 1;
    if (m_mode == 0) return bus ? 0 : 1;
    return 1;
  endfunction

  task automatic model_edge();
    int nmode, nlock, ncnt;
    if (rst) begin
      sq_stby = '{1, 1}; sq_vcc = '{0, 0}; sq_vio = '{0, 0};
      m_mode = 1; m_lock = 0; m_cnt = 0;
      return;
    end
    nmode = (sq_vcc[0] != 0 || sq_vio[0] != 0) ? 2 : (sq_stby[0] != 0 ? 1 : 0);
    nlock = m_lock;
    if (m_mode == 0) nlock = bus;
    else if (!bus) nlock = 0;
    if (m_mode == 0 || m_lock != 0 || !bus || sq_vio[0] != 0) ncnt = 0;
    else if (m_cnt < W) ncnt = m_cnt + 1;
    else ncnt = m_cnt;
    m_mode = nmode; m_lock = nlock; m_cnt = ncnt;
    void'(sq_stby.pop_front()); sq_stby.push_back(int'(stby));
    void'(sq_vcc.pop_front());  sq_vcc.push_back(int'(vcc_uv));
    void'(sq_vio.pop_front());  sq_vio.push_back(int'(vio_uv));
  endtask

  task automatic compare_all();
    string rtag;
    rtag = (vio_s() != 0) ? "R6" : ((m_mode == 0) ? "R9" : "R3");
    chk("R1 mode", int'(mode_a), m_mode);
    chk("R8 tx_en", int'(tx_a), (m_mode == 0) ? 1 : 0);
    chk("R6 rxd_oe", int'(oe_a), (vio_s() != 0) ? 0 : 1);
    chk({rtag, " rxd"}, int'(rxd_a), exp_rxd_wake());
    chk("R7 rxd variant", int'(rxd_b), exp_rxd_plain());
    chk("R2 mode variant", int'(mode_b), m_mode);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      #1;
      if (!rst) compare_all();
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    sq_stby = '{1, 1}; sq_vcc = '{0, 0}; sq_vio = '{0, 0};
    m_mode = 1; m_lock = 0; m_cnt = 0;
    rst = 1; stby = 1; vcc_uv = 0; vio_uv = 0; bus = 0;
    cyc(3);
    rst = 0;
    #1;
    // R11 reset state
    chk("R11 mode", int'(mode_a), 1);
    chk("R11 tx_en", int'(tx_a), 0);
    chk("R11 rxd_oe", int'(oe_a), 1);
    chk("R11 rxd", int'(rxd_a), 1);

    // R10 latency, R1 normal select
    stby = 0;
    cyc(2);
    chk("R10 mode held two edges", int'(mode_a), 1);
    cyc(1);
    chk("R1 normal", int'(mode_a), 0);
    chk("R8 tx_en normal", int'(tx_a), 1);

    // R9 pass-through
    bus = 1; #1;
    chk("R9 dominant passthrough", int'(rxd_a), 0);
    cyc(2);
    bus = 0; #1;
    chk("R9 recessive passthrough", int'(rxd_a), 1);
    cyc(2);

    // R1 standby, R8 driver off
    stby = 1;
    cyc(3);
    chk("R1 standby", int'(mode_a), 1);
    chk("R8 tx_en standby", int'(tx_a), 0);

    // R4 short pulse, then restart
    bus = 1; cyc(W - 1);
    bus = 0; cyc(1);
    chk("R4 short pulse no wake", int'(rxd_a), 1);
    bus = 1; cyc(W - 1);
    chk("R4 count restarted", int'(rxd_a), 1);
    cyc(1);
    chk("R3 wake at threshold", int'(rxd_a), 0);
    chk("R7 variant stays high", int'(rxd_b), 1);
    cyc(3);
    chk("R3 wake held", int'(rxd_a), 0);
    bus = 0; cyc(1);
    chk("R3 wake ends", int'(rxd_a), 1);

    // R5 lockout
    stby = 0; cyc(3);
    bus = 1; cyc(2);
    stby = 1; cyc(3 + 3 * W);
    chk("R5 lockout", int'(rxd_a), 1);
    bus = 0; cyc(1);
    bus = 1; cyc(W);
    chk("R5 lockout released", int'(rxd_a), 0);
    bus = 0; cyc(2);

    // R2 main-supply undervoltage
    stby = 0; cyc(3);
    vcc_uv = 1; cyc(3);
    chk("R2 vcc uv mode", int'(mode_a), 2);
    chk("R8 tx_en uv", int'(tx_a), 0);
    vcc_uv = 0; cyc(3);
    chk("R2 back to normal", int'(mode_a), 0);

    // R6 I/O undervoltage
    stby = 1; cyc(3);
    vio_uv = 1; cyc(2);
    chk("R6 oe low", int'(oe_a), 0);
    chk("R6 rxd high", int'(rxd_a), 1);
    cyc(1);
    chk("R2 vio uv mode", int'(mode_a), 2);
    bus = 1; cyc(2 * W);
    chk("R6 no wake", int'(rxd_a), 1);
    vio_uv = 0; cyc(2);
    chk("R6 oe back", int'(oe_a), 1);
    chk("R6 count held zero", int'(rxd_a), 1);
    cyc(W);
    chk("R3 wake after uv", int'(rxd_a), 0);
    bus = 0; cyc(2);

    // mixed stimulus against the reference model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 49) == 0) stby = ~stby;
      if ($urandom_range(0, 199) == 0) vcc_uv = ~vcc_uv;
      if ($urandom_range(0, 249) == 0) vio_uv = ~vio_uv;
      if ($urandom_range(0, 11) == 0) bus = ~bus;
      cyc(1);
    end

    done = 1'b1;
    report();
  end

endmodule